// File: doc/BRIEF.md
# Start-of-Frame Referenced RC Trim Calibrator

This block holds an RC oscillator on frequency by measuring it against the 1 ms frame-start pulse that a USB host sends. It counts cycles of the local clock between two frame-start pulses. It compares that count with eight ascending thresholds, which gives one of nine period buckets. Each bucket holds a programmable operation. The operation either leaves the 5-bit fine trim code alone, steps it by one, or moves it by a binary-search step that halves on each use.

When the fine code is stuck at one end of its range and the chosen operation still pushes it further, the block records an underrun or an overflow. If automatic coarse adjustment is enabled, the same event also moves an 8-bit coarse code by one, without wrapping. Firmware uses a small word-wide register port to set the thresholds, the nine operation bytes, the control bits and the interrupt mask. The same port reads the trim codes and the pending events, and clears the events.

Top module: `sof_trim_cal`

## Requirements
- R1: The first frame-start pulse after enable, or after any write to the control register (address 17, bit 0 enable, bit 1 halt-on-no-op, bit 2 auto-coarse), only starts the period count and leaves the trim codes unchanged. While enable is 0, pulses have no effect.
- R2: The measured period is the number of clock cycles from one pulse to the next. Its bucket is the number of thresholds (addresses 0 to 7, ascending) that it is greater than or equal to.
- R3: Operation byte encoding: bits [1:0] = 0 no-op, 1 binary step, 2 add, 3 subtract; bit 4 = 1 means binary down. Bucket b's byte sits at address 8+b. Reset contents: bucket 0 no-op; buckets 1–2 binary down (0x11); bucket 3 subtract (0x13); buckets 4–5 no-op; bucket 6 add (0x12); buckets 7–8 binary up (0x01).
- R4: Add raises the fine code by exactly 1 and subtract lowers it by exactly 1. Binary steps clamp at 0 and at 31 and raise no event when they clamp.
- R5: The binary step starts at 16 and halves after each binary operation, down to a floor of 1. It returns to 16 after any add, subtract or no-op, and after any write to the fine code.
- R6: An operation that lowers the code while the fine code is 0 leaves it at 0 and raises the underrun event (state bit 2).
- R7: An operation that raises the code while the fine code is 31 leaves it at 31 and raises the overflow event (state bit 3).
- R8: With auto-coarse set, an underrun decrements the coarse code and an overflow increments it. The coarse code stops at 0 and at 255.
- R9: Event state at address 19 is cleared by writing 1 to a bit. The irq output is high when a state bit is set and the matching bit (2 or 3) of the mask at address 18 is set.
- R10: With halt-on-no-op set, a no-op bucket stops all further calibration until the next control write.
- R11: The period counter saturates at its maximum. A saturated count falls in the top bucket.
- R12: After reset, fine = 16, coarse = 128, irq = 0, and the control, mask and state registers read 0.
- R13: Writes to address 20 load the fine code and writes to address 21 load the coarse code. Both codes read back at the same addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock being calibrated |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | One-cycle frame-start pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| fine_trim | output | FINE_W | Fine trim code |
| coarse_trim | output | COARSE_W | Coarse trim code |
| irq | output | 1 | Masked event request |

## Verification
A classified pulse updates the fine code, the coarse code, the event state and irq at the same clock edge that samples the pulse. Those results are therefore due exactly one cycle after the bench raises sof, and the bench samples them at the falling edge that follows. Register writes take effect at the next edge. Read data and irq are combinational from the registers, so the bench reads them half a cycle after each write. Every period is made by counting the exact number of idle edges between two pulses, so each measured count is known before the check.

// File: rtl/sofcal_pkg.sv
package sofcal_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_THR0   = 5'd0;
    localparam logic [ADDR_W-1:0] A_OP0    = 5'd8;
    localparam logic [ADDR_W-1:0] A_CTRL   = 5'd17;
    localparam logic [ADDR_W-1:0] A_IMASK  = 5'd18;
    localparam logic [ADDR_W-1:0] A_ISTATE = 5'd19;
    localparam logic [ADDR_W-1:0] A_FINE   = 5'd20;
    localparam logic [ADDR_W-1:0] A_COARSE = 5'd21;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_BIN = 2'd1,
        OP_ADD = 2'd2,
        OP_SUB = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic     down;
        op_kind_e kind;
    } op_t;

    typedef struct packed {
        logic over;
        logic under;
    } trim_ev_t;

    function automatic op_t decode_op(input logic [7:0] b);
        op_t o;
        o.kind = op_kind_e'(b[1:0]);
        o.down = b[4];
        return o;
    endfunction

    function automatic logic [7:0] default_op(input int bucket);
        case (bucket)
            1, 2:    return 8'h11;
            3:       return 8'h13;
            6:       return 8'h12;
            7, 8:    return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic longint default_thr(input int k, input longint tgt);
        case (k)
            0:       return tgt * 70 / 100;
            1:       return tgt * 80 / 100;
            2:       return tgt * 90 / 100;
            3:       return tgt * 998750 / 1000000;
            4:       return tgt;
            5:       return tgt * 1001250 / 1000000;
            6:       return tgt * 110 / 100;
            default: return tgt * 120 / 100;
        endcase
    endfunction

endpackage

// File: rtl/sofcal_period.sv
module sofcal_period #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             restart,
    input  logic             sof,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            if (sof)
                cnt_q <= CNT_W'(1);
            else if (cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;

            if (!en || restart)
                armed_q <= 1'b0;
            else if (sof)
                armed_q <= 1'b1;
        end
    end

    assign meas_valid = sof && armed_q && en && !restart;
    assign meas_cnt   = cnt_q;

    // R11
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !sof) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/sofcal_classify.sv
module sofcal_classify #(
    parameter int CNT_W = 16,
    parameter int NTHR  = 8,
    localparam int BK_W = $clog2(NTHR + 1)
) (
    input  logic [CNT_W-1:0]            cnt,
    input  logic [NTHR-1:0][CNT_W-1:0]  thr,
    output logic [BK_W-1:0]             bucket
);
    logic [NTHR-1:0] ge;

    for (genvar k = 0; k < NTHR; k++) begin : g_cmp
        assign ge[k] = (cnt >= thr[k]);
    end

    always_comb begin
        bucket = '0;
        for (int k = 0; k < NTHR; k++)
            if (ge[k]) bucket = bucket + BK_W'(1);
    end
endmodule

// File: rtl/sofcal_trim.sv
module sofcal_trim
    import sofcal_pkg::*;
#(
    parameter int FINE_W      = 5,
    parameter int COARSE_W    = 8,
    parameter int FINE_INIT   = 16,
    parameter int COARSE_INIT = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                apply,
    input  op_t                 op,
    input  logic                fine_we,
    input  logic [FINE_W-1:0]   fine_wdata,
    input  logic                coarse_we,
    input  logic [COARSE_W-1:0] coarse_wdata,
    input  logic                auto_coarse,
    output logic [FINE_W-1:0]   fine,
    output logic [COARSE_W-1:0] coarse,
    output trim_ev_t            ev
);
    localparam logic [FINE_W-1:0]   FMAX = '1;
    localparam logic [FINE_W-1:0]   HALF = FINE_W'(1 << (FINE_W - 1));
    localparam logic [COARSE_W-1:0] CMAX = '1;

    logic [FINE_W-1:0] fine_q, step_q, fine_n, step_n;
    logic [COARSE_W-1:0] coarse_q;

    always_comb begin
        fine_n = fine_q;
        step_n = step_q;
        ev     = '0;
        if (apply) begin
            case (op.kind)
                OP_NOP: step_n = HALF;
                OP_ADD: begin
                    step_n = HALF;
                    if (fine_q == FMAX) ev.over = 1'b1;
                    else                fine_n = fine_q + 1'b1;
                end
                OP_SUB: begin
                    step_n = HALF;
                    if (fine_q == '0) ev.under = 1'b1;
                    else              fine_n = fine_q - 1'b1;
                end
                default: begin
                    step_n = (step_q == FINE_W'(1)) ? step_q : (step_q >> 1);
                    if (op.down) begin
                        if (fine_q == '0)        ev.under = 1'b1;
                        else if (fine_q > step_q) fine_n = fine_q - step_q;
                        else                      fine_n = '0;
                    end else begin
                        if (fine_q == FMAX)              ev.over = 1'b1;
                        else if ((FMAX - fine_q) > step_q) fine_n = fine_q + step_q;
                        else                               fine_n = FMAX;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fine_q   <= FINE_W'(FINE_INIT);
            step_q   <= HALF;
            coarse_q <= COARSE_W'(COARSE_INIT);
        end else begin
            if (fine_we) begin
                fine_q <= fine_wdata;
                step_q <= HALF;
            end else begin
                fine_q <= fine_n;
                step_q <= step_n;
            end
            if (coarse_we)
                coarse_q <= coarse_wdata;
            else if (auto_coarse && ev.under && coarse_q != '0)
                coarse_q <= coarse_q - 1'b1;
            else if (auto_coarse && ev.over && coarse_q != CMAX)
                coarse_q <= coarse_q + 1'b1;
        end
    end

    assign fine   = fine_q;
    assign coarse = coarse_q;

    // R5
    step_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot(step_q));
    // R4
    add_one_chk: assert property (@(posedge clk) disable iff (rst)
        (apply && op.kind == OP_ADD && fine_q != FMAX && !fine_we)
        |=> fine_q == $past(fine_q) + 1'b1);
    // R8
    coarse_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.under && coarse_q == '0 && !coarse_we) |=> coarse_q == '0);
    // R8
    coarse_ceil_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.over && coarse_q == CMAX && !coarse_we) |=> coarse_q == CMAX);
endmodule

// File: rtl/sof_trim_cal.sv
module sof_trim_cal
    import sofcal_pkg::*;
#(
    parameter int REF_HZ      = 24_000_000,
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 16,
    parameter int NTHR        = 8,
    parameter int FINE_W      = 5,
    parameter int COARSE_W    = 8,
    parameter int FINE_INIT   = 16,
    parameter int COARSE_INIT = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sof,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [FINE_W-1:0]   fine_trim,
    output logic [COARSE_W-1:0] coarse_trim,
    output logic                irq
);
    localparam int     NBKT   = NTHR + 1;
    localparam int     BK_W   = $clog2(NBKT);
    localparam longint TARGET = longint'(REF_HZ) / 1000;

    logic [NTHR-1:0][CNT_W-1:0] thr_q;
    logic [NBKT-1:0][7:0]       op_q;
    logic       en_q, stop_q, auto_q, halted_q;
    trim_ev_t   imask_q, istate_q, ev;

    logic             ctrl_wr, fine_we, coarse_we, meas_valid, apply;
    logic [CNT_W-1:0] meas_cnt;
    logic [BK_W-1:0]  bucket;
    logic [7:0]       op_byte;
    op_t              op;

    assign ctrl_wr   = reg_we && reg_addr == A_CTRL;
    assign fine_we   = reg_we && reg_addr == A_FINE;
    assign coarse_we = reg_we && reg_addr == A_COARSE;

    sofcal_period #(.CNT_W(CNT_W)) u_period (
        .clk(clk), .rst(rst), .en(en_q), .restart(ctrl_wr), .sof(sof),
        .meas_valid(meas_valid), .meas_cnt(meas_cnt)
    );

    sofcal_classify #(.CNT_W(CNT_W), .NTHR(NTHR)) u_classify (
        .cnt(meas_cnt), .thr(thr_q), .bucket(bucket)
    );

    always_comb begin
        op_byte = '0;
        for (int b = 0; b < NBKT; b++)
            if (bucket == BK_W'(b)) op_byte = op_q[b];
    end

    assign op    = decode_op(op_byte);
    assign apply = meas_valid && !halted_q;

    sofcal_trim #(
        .FINE_W(FINE_W), .COARSE_W(COARSE_W),
        .FINE_INIT(FINE_INIT), .COARSE_INIT(COARSE_INIT)
    ) u_trim (
        .clk(clk), .rst(rst), .apply(apply), .op(op),
        .fine_we(fine_we), .fine_wdata(reg_wdata[FINE_W-1:0]),
        .coarse_we(coarse_we), .coarse_wdata(reg_wdata[COARSE_W-1:0]),
        .auto_coarse(auto_q), .fine(fine_trim), .coarse(coarse_trim), .ev(ev)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NTHR; k++)
                thr_q[k] <= CNT_W'(default_thr(k, TARGET));
            for (int b = 0; b < NBKT; b++)
                op_q[b] <= default_op(b);
            en_q     <= 1'b0;
            stop_q   <= 1'b0;
            auto_q   <= 1'b0;
            halted_q <= 1'b0;
            imask_q  <= '0;
            istate_q <= '0;
        end else begin
            if (reg_we) begin
                for (int k = 0; k < NTHR; k++)
                    if (reg_addr == A_THR0 + ADDR_W'(k))
                        thr_q[k] <= reg_wdata[CNT_W-1:0];
                for (int b = 0; b < NBKT; b++)
                    if (reg_addr == A_OP0 + ADDR_W'(b))
                        op_q[b] <= reg_wdata[7:0];
                if (reg_addr == A_IMASK)
                    imask_q <= trim_ev_t'(reg_wdata[3:2]);
            end
            if (ctrl_wr) begin
                en_q   <= reg_wdata[0];
                stop_q <= reg_wdata[1];
                auto_q <= reg_wdata[2];
            end
            if (reg_we && reg_addr == A_ISTATE)
                istate_q <= (istate_q & ~trim_ev_t'(reg_wdata[3:2])) | ev;
            else
                istate_q <= istate_q | ev;
            if (ctrl_wr)
                halted_q <= 1'b0;
            else if (apply && stop_q && op.kind == OP_NOP)
                halted_q <= 1'b1;
        end
    end

    assign irq = |(istate_q & imask_q);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:   reg_rdata[3:0] = {halted_q, auto_q, stop_q, en_q};
            A_IMASK:  reg_rdata[3:2] = imask_q;
            A_ISTATE: reg_rdata[3:2] = istate_q;
            A_FINE:   reg_rdata[FINE_W-1:0] = fine_trim;
            A_COARSE: reg_rdata[COARSE_W-1:0] = coarse_trim;
            default:  reg_rdata = '0;
        endcase
    end

    // R10
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (halted_q && !reg_we) |=> $stable(fine_trim));
    // R6
    under_latch_chk: assert property (@(posedge clk) disable iff (rst)
        ev.under |=> istate_q.under);
    // R7
    over_latch_chk: assert property (@(posedge clk) disable iff (rst)
        ev.over |=> istate_q.over);
endmodule

// File: tb/tb_sof_trim_cal.sv
`timescale 1ns/1ps
module tb_sof_trim_cal;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sof = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [4:0]  fine_trim;
    logic [7:0]  coarse_trim;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sof_trim_cal #(.REF_HZ(100_000), .CNT_W(8), .DATA_W(16)) dut (
        .clk(clk), .rst(rst), .sof(sof), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fine_trim(fine_trim),
        .coarse_trim(coarse_trim), .irq(irq)
    );

    // {fine preset, period, expected fine, expected events {over,under}}
    localparam logic [31:0] VEC [15] = '{
        32'h100A_1000, 32'h1019_0000, 32'h1423_0400, 32'h142D_1300,
        32'h1431_1400, 32'h1437_1500, 32'h0A41_1A00, 32'h1450_1F00,
        32'h002D_0001, 32'h1F37_1F02, 32'h0019_0001, 32'h1F50_1F02,
        32'h1430_1400, 32'h1432_1400, 32'h1434_1500
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output int v);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic pulse();
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
    endtask

    task automatic period(input int p);
        repeat (p - 1) @(negedge clk);
        pulse();
    endtask

    task automatic setup(input logic [15:0] ctrl, input logic [15:0] fine);
        wr(5'd17, ctrl);
        wr(5'd20, fine);
        wr(5'd19, 16'h000C);
        pulse();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int v;
        logic [15:0] thr [8] = '{16'd20, 16'd30, 16'd40, 16'd48,
                                 16'd50, 16'd52, 16'd60, 16'd70};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        chk("R12 fine", int'(fine_trim), 16);
        chk("R12 coarse", int'(coarse_trim), 128);
        chk("R12 irq", int'(irq), 0);
        rd(5'd19, v); chk("R12 state", v, 0);
        rd(5'd17, v); chk("R12 ctrl", v, 0);
        rd(5'd18, v); chk("R12 mask", v, 0);

        for (int k = 0; k < 8; k++) wr(5'(k), thr[k]);

        // R2 R3 R4 R5 R6 R7: table of single measurements, default operations
        for (int i = 0; i < 15; i++) begin
            setup(16'h1, 16'(VEC[i][31:24]));
            period(int'(VEC[i][23:16]));
            chk($sformatf("R2/R3 vector %0d fine", i), int'(fine_trim), int'(VEC[i][15:8]));
            rd(5'd19, v);
            chk($sformatf("R6/R7 vector %0d events", i), v >> 2, int'(VEC[i][7:0]));
        end
        chk("R8 coarse untouched without auto", int'(coarse_trim), 128);
        rd(5'd20, v); chk("R13 fine readback", v, 21);

        // R5 binary halving 16,8,4,2,1 then overflow at 31
        setup(16'h1, 16'd0);
        period(65); chk("R5 step16", int'(fine_trim), 16);
        period(65); chk("R5 step8", int'(fine_trim), 24);
        period(65); chk("R5 step4", int'(fine_trim), 28);
        period(65); chk("R5 step2", int'(fine_trim), 30);
        period(65); chk("R5 step1", int'(fine_trim), 31);
        period(65); rd(5'd19, v); chk("R7 over after search", v, 8);

        // R5 step restored by add
        setup(16'h1, 16'd0);
        period(65); chk("R5 first", int'(fine_trim), 16);
        period(55); chk("R4 add", int'(fine_trim), 17);
        period(65); chk("R5 step back to 16", int'(fine_trim), 31);

        // R8 R9 auto coarse, mask, write-1-to-clear
        wr(5'd18, 16'h0004);
        setup(16'h5, 16'd0);
        period(45);
        chk("R8 coarse dec", int'(coarse_trim), 127);
        chk("R9 irq", int'(irq), 1);
        wr(5'd18, 16'h0008);
        chk("R9 masked", int'(irq), 0);
        wr(5'd19, 16'h0004);
        rd(5'd19, v); chk("R9 w1c", v, 0);
        wr(5'd21, 16'h00FF);
        setup(16'h5, 16'd31);
        period(55); chk("R8 ceiling", int'(coarse_trim), 255);
        chk("R9 irq over", int'(irq), 1);
        wr(5'd21, 16'h0000);
        rd(5'd21, v); chk("R13 coarse load", v, 0);
        setup(16'h5, 16'd0);
        period(45); chk("R8 floor", int'(coarse_trim), 0);

        // R11 saturation: 300 cycles counted as 255, top bucket
        setup(16'h1, 16'd10);
        period(300); chk("R11 saturated top bucket", int'(fine_trim), 26);

        // R10 halt on no-op
        setup(16'h3, 16'd20);
        period(10); chk("R10 nop", int'(fine_trim), 20);
        rd(5'd17, v); chk("R10 halted flag", (v >> 3) & 1, 1);
        period(55); chk("R10 halted ignores add", int'(fine_trim), 20);
        setup(16'h1, 16'd20);
        period(55); chk("R10 resumed", int'(fine_trim), 21);

        // R1 disabled, and first pulse only arms
        setup(16'h0, 16'd20);
        period(55); chk("R1 disabled", int'(fine_trim), 20);
        wr(5'd17, 16'h1);
        wr(5'd20, 16'd20);
        repeat (300) @(negedge clk);
        pulse(); chk("R1 first pulse arms only", int'(fine_trim), 20);

        // R3 reprogrammed bucket 4 to subtract
        wr(5'd12, 16'h0013);
        setup(16'h1, 16'd20);
        period(49); chk("R3 programmed op", int'(fine_trim), 19);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule